// File: doc/BRIEF.md
# Two-Level Decoded Arithmetic Logic Unit

This block is the arithmetic core of a simple multi-cycle processor datapath. It is purely combinational and takes two 32-bit operands, a 2-bit operation-class code from the main sequencer and the 6-bit function field of a register-to-register instruction. It returns a 32-bit result and a flag that is high when that result is zero. The sequencer uses the flag to decide whether an equal-compare branch is taken.

Control is decoded in two stages. The first stage reduces the class code and the function field to a 3-bit internal operation select. The second stage runs one of five operations on the operands: bitwise AND, bitwise OR, addition, subtraction, or signed set-on-less-than.

The class code controls which information the decode uses. Class `00` means address arithmetic for loads and stores, and forces addition. Any class with bit 0 set means a branch compare, and forces subtraction. Class `10` hands the choice to the low four function bits.

Top module: `twolevel_alu`

## Requirements
- R1: With op_class = 00, result = opnd_a + opnd_b (mod 2^32) for every fn_code.
- R2: With op_class = 01 or 11, result = opnd_a - opnd_b (mod 2^32) for every fn_code.
- R3: With op_class = 10 and fn_code[3:0] = 0000, result = opnd_a + opnd_b (mod 2^32).
- R4: With op_class = 10 and fn_code[3:0] = 0010, result = opnd_a - opnd_b (mod 2^32), wrapping on borrow.
- R5: With op_class = 10 and fn_code[3:0] = 0100, result = opnd_a & opnd_b.
- R6: With op_class = 10 and fn_code[3:0] = 0101, result = opnd_a | opnd_b.
- R7: With op_class = 10 and fn_code[3:0] = 1010, result[0] = 1 when opnd_a < opnd_b as signed two's-complement values and 0 otherwise, and result[31:1] = 0. This holds even when the difference overflows.
- R8: fn_code[5:4] has no effect on result or is_zero for any op_class.
- R9: With op_class = 10 and any fn_code[3:0] other than the five listed codes, result = opnd_a + opnd_b (mod 2^32).
- R10: is_zero = 1 exactly when result = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_class | input | 2 | Operation class from the sequencer: 00 address add, x1 compare, 10 function-field decode |
| fn_code | input | 6 | Function field of a register-format instruction |
| result | output | 32 | Operation result |
| is_zero | output | 1 | High when result is all zeros |

## Verification
Every path is combinational, so a wrong decoded operation select appears on `result` as soon as the inputs settle, with no delay. The typical symptom is a sum where a difference was expected, and the bench compares each settled output against a model written separately from the design. A set-on-less-than with the wrong sign handling only shows when the operand signs differ and the difference overflows, so the stimulus targets those operand pairs on purpose. A zero flag that is out of step with the result breaks the branch decision only when the result is exactly zero, so equal-operand compares are driven under every class that subtracts.

// File: rtl/twolevel_alu_pkg.sv
package twolevel_alu_pkg;

  // Internal operation select; the encoding is the contract between the
  // decode stage and the execute stage.
  typedef enum logic [2:0] {
    OPS_AND = 3'b000,
    OPS_OR  = 3'b001,
    OPS_ADD = 3'b010,
    OPS_SUB = 3'b110,
    OPS_SLT = 3'b111
  } op_sel_t;

  localparam int unsigned CLASS_W = 2;
  localparam int unsigned FN_W    = 6;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import twolevel_alu_pkg::*;
(
  input  logic [CLASS_W-1:0] op_class,
  input  logic [FN_W-1:0]    fn_code,
  output op_sel_t            op_sel
);

  // Second-level decode of the function field; upper two bits are don't-care.
  function automatic op_sel_t fn_to_sel(input logic [FN_W-1:0] fn);
    op_sel_t s;
    casez (fn)
      6'b??0000: s = OPS_ADD;
      6'b??0010: s = OPS_SUB;
      6'b??0100: s = OPS_AND;
      6'b??0101: s = OPS_OR;
      6'b??1010: s = OPS_SLT;
      default:   s = OPS_ADD;
    endcase
    return s;
  endfunction

  always_comb begin
    if (op_class[0])
      op_sel = OPS_SUB;              // compare class wins over bit 1
    else if (!op_class[1])
      op_sel = OPS_ADD;              // address arithmetic
    else
      op_sel = fn_to_sel(fn_code);
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub_en,
  output logic [W-1:0] sum,
  output logic         lt_signed
);

  localparam int unsigned MSB = W - 1;

  logic [W-1:0] b_eff;
  logic         sum_neg;
  logic         sum_ovf;

  function automatic logic [W-1:0] add_cin(input logic [W-1:0] x,
                                           input logic [W-1:0] y,
                                           input logic         cin);
    return x + y + {{(W-1){1'b0}}, cin};
  endfunction

  function automatic logic signed_ovf(input logic xs, input logic ys,
                                      input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  assign b_eff     = sub_en ? ~b : b;
  assign sum       = add_cin(a, b_eff, sub_en);
  assign sum_neg   = sum[MSB];
  assign sum_ovf   = signed_ovf(a[MSB], b_eff[MSB], sum[MSB]);
  assign lt_signed = sum_neg ^ sum_ovf;

endmodule

// File: rtl/alu_select.sv
module alu_select
  import twolevel_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  op_sel_t      op_sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] sum,
  input  logic         lt_signed,
  output logic [W-1:0] y
);

  logic [W-1:0] and_v;
  logic [W-1:0] or_v;
  logic [W-1:0] slt_v;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_v[i] = a[i] & b[i];
    assign or_v[i]  = a[i] | b[i];
    if (i == 0) begin : g_lsb
      assign slt_v[i] = lt_signed;
    end else begin : g_upper
      assign slt_v[i] = 1'b0;
    end
  end

  always_comb begin
    unique case (op_sel)
      OPS_AND: y = and_v;
      OPS_OR:  y = or_v;
      OPS_SLT: y = slt_v;
      default: y = sum;              // add and subtract share the adder
    endcase
  end

endmodule

// File: rtl/twolevel_alu.sv
module twolevel_alu
  import twolevel_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]   opnd_a,
  input  logic [WIDTH-1:0]   opnd_b,
  input  logic [CLASS_W-1:0] op_class,
  input  logic [FN_W-1:0]    fn_code,
  output logic [WIDTH-1:0]   result,
  output logic               is_zero
);

  op_sel_t          op_sel;
  logic             sub_en;
  logic [WIDTH-1:0] sum;
  logic             lt_signed;

  alu_op_decode u_decode (
    .op_class (op_class),
    .fn_code  (fn_code),
    .op_sel   (op_sel)
  );

  assign sub_en = (op_sel == OPS_SUB) || (op_sel == OPS_SLT);

  alu_addsub #(.W(WIDTH)) u_addsub (
    .a         (opnd_a),
    .b         (opnd_b),
    .sub_en    (sub_en),
    .sum       (sum),
    .lt_signed (lt_signed)
  );

  alu_select #(.W(WIDTH)) u_select (
    .op_sel    (op_sel),
    .a         (opnd_a),
    .b         (opnd_b),
    .sum       (sum),
    .lt_signed (lt_signed),
    .y         (result)
  );

  assign is_zero = ~|result;

endmodule

// File: rtl/twolevel_alu_chk.sv
module twolevel_alu_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [1:0]       op_class,
  input logic [5:0]       fn_code,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             is_zero
);

  always_comb begin
    // R1: address class always decodes to add
    a_r1_class_add: assert (!(op_class == 2'b00) || op_sel == 3'b010);
    // R2: compare classes always decode to subtract
    a_r2_class_sub: assert (!op_class[0] || op_sel == 3'b110);
    // R4: a subtract select yields the wrapped difference
    a_r4_sub_value: assert (op_sel != 3'b110 || result == opnd_a - opnd_b);
    // R7: set-on-less-than clears every bit above bit 0
    a_r7_slt_upper_clear: assert (op_sel != 3'b111 || result[WIDTH-1:1] == '0);
    // R7: set-on-less-than agrees with a signed comparison
    a_r7_slt_signed: assert (op_sel != 3'b111 ||
                             result[0] == ($signed(opnd_a) < $signed(opnd_b)));
    // R9: a function code outside the listed set falls back to add
    a_r9_default_add: assert (!(op_class == 2'b10 &&
                                fn_code[3:0] != 4'b0000 && fn_code[3:0] != 4'b0010 &&
                                fn_code[3:0] != 4'b0100 && fn_code[3:0] != 4'b0101 &&
                                fn_code[3:0] != 4'b1010) ||
                              result == opnd_a + opnd_b);
    // R10: flag tracks an all-zero result
    a_r10_zero_flag: assert (is_zero == (result == '0));
  end

endmodule

bind twolevel_alu twolevel_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .op_class (op_class),
  .fn_code  (fn_code),
  .op_sel   (op_sel),
  .result   (result),
  .is_zero  (is_zero)
);

// File: tb/twolevel_alu_bench.sv
module twolevel_alu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [1:0]  op_class = '0;
  logic [5:0]  fn_code = '0;
  logic [31:0] result;
  logic        is_zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] q_res[$];
  logic        q_zero[$];
  string       q_tag[$];

  always #10 clk = ~clk;   // 50 MHz

  twolevel_alu u_twolevel_alu (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .op_class (op_class),
    .fn_code  (fn_code),
    .result   (result),
    .is_zero  (is_zero)
  );

  // Reference written from the requirements.
  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [1:0] cls, input logic [5:0] fn);
    logic [31:0] r;
    if (cls == 2'b00) r = a + b;
    else if (cls[0]) r = a - b;
    else begin
      case (fn[3:0])
        4'd0:    r = a + b;
        4'd2:    r = a - b;
        4'd4:    r = a & b;
        4'd5:    r = a | b;
        4'd10:   r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        default: r = a + b;
      endcase
    end
    return r;
  endfunction

  // Driver: applies one vector after a rising edge and queues its expectation.
  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] cls, input logic [5:0] fn, input string tag);
    logic [31:0] e;
    @(posedge clk);
    #2;
    opnd_a = a; opnd_b = b; op_class = cls; fn_code = fn;
    e = model(a, b, cls, fn);
    q_res.push_back(e);
    q_zero.push_back(e == 32'd0);
    q_tag.push_back(tag);
  endtask

  // Monitor: compares settled outputs at the falling edge.
  always @(negedge clk) begin
    if (rst_n && q_res.size() > 0) begin
      logic [31:0] er;
      logic        ez;
      string       t;
      er = q_res.pop_front();
      ez = q_zero.pop_front();
      t  = q_tag.pop_front();
      checks++;
      if (result !== er || is_zero !== ez) begin
        errors++;
        $display("FAIL %s result=%h zero=%b expected result=%h zero=%b",
                 t, result, is_zero, er, ez);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog result=%h zero=%b expected completion", result, is_zero);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    lf = 32'hACE1_2345;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset-state check: all-zero inputs give a zero sum with the flag set (R10).
    drive(32'd0, 32'd0, 2'b00, 6'd0, "R10 idle");

    drive(32'd7, 32'd5, 2'b00, 6'b001010, "R1");
    drive(32'hFFFF_FFFF, 32'd1, 2'b00, 6'b100010, "R1 wrap");
    drive(32'd9, 32'd4, 2'b01, 6'b000000, "R2 cls01");
    drive(32'd9, 32'd4, 2'b11, 6'b100100, "R2 cls11");
    drive(32'h1234, 32'h1234, 2'b01, 6'd0, "R2 R10 equal");
    drive(32'h8000_0000, 32'h8000_0000, 2'b11, 6'b000101, "R2 R10 equal neg");
    drive(32'h1000_0000, 32'h2345_6789, 2'b10, 6'b100000, "R3");
    drive(32'd3, 32'd5, 2'b10, 6'b100010, "R4 borrow");
    drive(32'd5, 32'd5, 2'b10, 6'b000010, "R4 R10 zero");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 2'b10, 6'b100100, "R5");
    drive(32'hF0F0_0000, 32'h0F0F_0000, 2'b10, 6'b000100, "R5 R10 disjoint");
    drive(32'hF000_0001, 32'h0000_1230, 2'b10, 6'b100101, "R6");
    drive(32'hFFFF_FFFF, 32'd1, 2'b10, 6'b101010, "R7 neg<pos");
    drive(32'd1, 32'hFFFF_FFFF, 2'b10, 6'b101010, "R7 pos>neg");
    drive(32'h8000_0000, 32'd1, 2'b10, 6'b101010, "R7 ovf min");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 2'b10, 6'b101010, "R7 ovf max");
    drive(32'd4, 32'd4, 2'b10, 6'b001010, "R7 R10 equal");
    drive(32'd3, 32'd9, 2'b10, 6'b011010, "R7 small");
    // R8: same low bits, every upper-bit pattern, every class.
    for (int c = 0; c < 4; c++)
      for (int h = 0; h < 4; h++)
        for (int l = 0; l < 16; l++)
          drive(32'h8765_4321, 32'h89AB_CDEF, c[1:0], {h[1:0], l[3:0]}, "R8 R9");
    // Mixed operands across all function codes.
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      b = (i % 5 == 0) ? a : lf;
      drive(a, b, lf[1:0], lf[7:2], "R1 R2 R3 R4 R5 R6 R7 R9 R10 mix");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule